// File: doc/BRIEF.md
# Sticky First-Error Capture Logger

This block sits beside a memory-side interconnect target and judges every request it accepts. Each accepted request gets exactly one response, one clock later. That response carries an error flag if any of four fault conditions was true for the request: the request arrived while the power manager was asking the target to go idle, the command was flagged as illegal, the protection lookup reported overlapping regions, or the protection lookup reported an access violation. The protection lookup and the command decoder are outside the block, and their verdicts arrive as single-bit inputs.

The first faulty request is recorded in two software-visible registers. One holds the faulting address. The other holds a one-hot cause field and a valid flag. While the flag is set, the record is frozen and later faults are only answered with error responses. Software reads the record through a small register port, then writes 1 to the flag position to re-arm the logger. An interrupt line mirrors the flag.

Top module: `errlog_top`

## Requirements
- R1: After reset, rsp_valid and irq are 0, and both registers (address register at reg_sel=0, cause register at reg_sel=1) read 0.
- R2: Each cycle with req_valid=1 produces exactly one cycle of rsp_valid=1 on the next clock cycle, and no other cycle has rsp_valid=1.
- R3: rsp_err is 1 with the response if and only if, in the request's cycle, at least one of idle_req, cmd_illegal, prot_overlap or prot_violation was 1.
- R4: When a faulty request is logged, the address register (reg_sel=0) reads that request's address, zero-extended to DATA_W.
- R5: The cause register (reg_sel=1) has the valid flag in bit 0 and the causes in bits 4:1: bit 1 request during idle, bit 2 illegal command, bit 3 region overlap, bit 4 protection violation. All causes present in the logged request are set together.
- R6: While the valid flag is set and no clear is written, later faulty requests leave both registers unchanged.
- R7: A write with reg_sel=1 and reg_wdata bit 0 = 1 clears the valid flag and the cause bits and leaves the address register unchanged. A write with bit 0 = 0, or a write with reg_sel=0, changes nothing.
- R8: If a faulty request and a clear write fall in the same cycle, the new fault is logged and the valid flag stays set.
- R9: irq equals the valid flag at all times.
- R10: A request with no fault condition never alters either register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A request is presented and accepted this cycle |
| req_addr | input | ADDR_W | Address of the request |
| idle_req | input | 1 | Power manager is requesting idle |
| cmd_illegal | input | 1 | Command decoder flags the request's command as illegal |
| prot_overlap | input | 1 | Protection lookup found overlapping regions |
| prot_violation | input | 1 | Protection lookup denied the access |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_err | output | 1 | Response carries an error |
| reg_sel | input | 1 | Register select: 0 address, 1 cause/valid |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_sel |
| irq | output | 1 | Error interrupt, follows the valid flag |

## Verification
The bench sends faults back to back so a logger that overwrote its record on every fault would show the last address and cause instead of the first. It writes the clear in the same cycle as a new fault, where a design that gave the clear priority would come up empty with the interrupt low. It also sends a clean request together with a clear. Writes with the wrong register or with bit 0 at zero must not re-arm the logger, and a design that decoded them loosely would drop its record. A scoreboard pairs every request with exactly one response. A dropped, duplicated or mis-flagged response, including one for a fault that arrived while the record was locked, leaves a mismatch or a leftover entry.

// File: rtl/errlog_pkg.sv
package errlog_pkg;
    localparam int CAUSE_W    = 4;
    localparam int C_IDLE     = 0;
    localparam int C_ILLEGAL  = 1;
    localparam int C_OVERLAP  = 2;
    localparam int C_PROT     = 3;
    typedef logic [CAUSE_W-1:0] cause_t;
endpackage

// File: rtl/errlog_detect.sv
module errlog_detect
    import errlog_pkg::*;
(
    input  logic   req_valid,
    input  logic   idle_req,
    input  logic   cmd_illegal,
    input  logic   prot_overlap,
    input  logic   prot_violation,
    output cause_t cause,
    output logic   fault
);
    always_comb begin
        cause            = '0;
        cause[C_IDLE]    = req_valid & idle_req;
        cause[C_ILLEGAL] = req_valid & cmd_illegal;
        cause[C_OVERLAP] = req_valid & prot_overlap;
        cause[C_PROT]    = req_valid & prot_violation;
        fault            = |cause;
    end
endmodule

// File: rtl/errlog_resp.sv
module errlog_resp (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic fault,
    output logic rsp_valid,
    output logic rsp_err
);
    typedef struct packed {
        logic vld;
        logic err;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d     = rsp_q;
        rsp_d.vld = req_valid;
        rsp_d.err = req_valid & fault;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.vld;
    assign rsp_err   = rsp_q.err;

    a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r3_err_only_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid);
endmodule

// File: rtl/errlog_capture.sv
module errlog_capture
    import errlog_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault,
    input  cause_t            cause,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              clr,
    output logic              valid,
    output logic [ADDR_W-1:0] addr,
    output cause_t            cause_q
);
    typedef struct packed {
        logic              vld;
        cause_t            cause;
        logic [ADDR_W-1:0] addr;
    } rec_t;

    rec_t rec_d, rec_q;
    logic armed;

    always_comb begin
        rec_d = rec_q;
        armed = ~rec_q.vld | clr;
        if (fault && armed) begin
            rec_d.vld   = 1'b1;
            rec_d.cause = cause;
            rec_d.addr  = req_addr;
        end else if (clr) begin
            rec_d.vld   = 1'b0;
            rec_d.cause = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rec_q <= '0;
        else        rec_q <= rec_d;
    end

    assign valid   = rec_q.vld;
    assign addr    = rec_q.addr;
    assign cause_q = rec_q.cause;

    a_r6_locked_record: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !clr) |=> ($stable(addr) && $stable(cause_q) && valid));
    a_r8_clear_with_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && fault) |=> valid);
    a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !fault) |=> (!valid && cause_q == '0 && $stable(addr)));
    a_r5_cause_when_valid: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (cause_q != '0));
    a_r5_empty_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (cause_q == '0));
    a_r10_clean_no_log: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault && !clr) |=> ($stable(addr) && $stable(cause_q) && $stable(valid)));
endmodule

// File: rtl/errlog_top.sv
module errlog_top
    import errlog_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              idle_req,
    input  logic              cmd_illegal,
    input  logic              prot_overlap,
    input  logic              prot_violation,
    output logic              rsp_valid,
    output logic              rsp_err,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    localparam int CREG_W = CAUSE_W + 1;

    cause_t              cause, cause_q;
    logic                fault, clr, valid;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   addr_word, cause_word;

    assign clr = reg_wr & reg_sel & reg_wdata[0];

    errlog_detect u_detect (
        .req_valid     (req_valid),
        .idle_req      (idle_req),
        .cmd_illegal   (cmd_illegal),
        .prot_overlap  (prot_overlap),
        .prot_violation(prot_violation),
        .cause         (cause),
        .fault         (fault)
    );

    errlog_resp u_resp (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .fault    (fault),
        .rsp_valid(rsp_valid),
        .rsp_err  (rsp_err)
    );

    errlog_capture #(.ADDR_W(ADDR_W)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .fault   (fault),
        .cause   (cause),
        .req_addr(req_addr),
        .clr     (clr),
        .valid   (valid),
        .addr    (addr_q),
        .cause_q (cause_q)
    );

    generate
        if (ADDR_W < DATA_W) begin : g_addr_pad
            assign addr_word = {{(DATA_W-ADDR_W){1'b0}}, addr_q};
        end else begin : g_addr_trunc
            assign addr_word = addr_q[DATA_W-1:0];
        end
        if (CREG_W < DATA_W) begin : g_cause_pad
            assign cause_word = {{(DATA_W-CREG_W){1'b0}}, cause_q, valid};
        end else begin : g_cause_fit
            assign cause_word = DATA_W'({cause_q, valid});
        end
    endgenerate

    assign reg_rdata = reg_sel ? cause_word : addr_word;
    assign irq       = valid;

    a_r3_err_matches_fault: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_err == $past(idle_req | cmd_illegal | prot_overlap | prot_violation)));
    a_r9_irq_valid_bit: assert property (@(posedge clk) disable iff (!rst_n)
        irq == cause_word[0]);
endmodule

// File: tb/errlog_top_tb.sv
module errlog_top_tb;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              idle_req = 1'b0, cmd_illegal = 1'b0;
    logic              prot_overlap = 1'b0, prot_violation = 1'b0;
    logic              rsp_valid, rsp_err;
    logic              reg_sel = 1'b0, reg_wr = 1'b0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    bit exp_q[$];

    bit                m_valid = 0;
    logic [ADDR_W-1:0] m_addr  = '0;
    logic [3:0]        m_cause = '0;

    always #10 clk = ~clk;

    errlog_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .idle_req(idle_req), .cmd_illegal(cmd_illegal), .prot_overlap(prot_overlap),
        .prot_violation(prot_violation), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: every response pops one expected item (R2, R3)
    always @(negedge clk) begin
        if (rst_n && !done && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected response", 1, 0);
            end else begin
                bit e;
                e = exp_q.pop_front();
                check("R3 response error flag", {31'b0, rsp_err}, {31'b0, e});
            end
        end
    end

    // Driver: one cycle of stimulus; updates the reference record and queue
    task automatic drive(input bit v, input logic [ADDR_W-1:0] a, input bit idl, input bit ill,
                         input bit ovl, input bit prt, input bit wr, input bit sel, input bit wd0);
        logic [3:0] cv;
        bit f, c;
        @(negedge clk);
        req_valid = v; req_addr = a;
        idle_req = idl; cmd_illegal = ill; prot_overlap = ovl; prot_violation = prt;
        reg_wr = wr; reg_sel = sel; reg_wdata = {31'b0, wd0};
        cv = v ? {prt, ovl, ill, idl} : 4'b0;
        f  = |cv;
        c  = wr & sel & wd0;
        if (v) exp_q.push_back(f);
        if (f && (!m_valid || c)) begin
            m_valid = 1; m_addr = a; m_cause = cv;
        end else if (c) begin
            m_valid = 0; m_cause = '0;
        end
    endtask

    task automatic req(input logic [ADDR_W-1:0] a, input bit idl, input bit ill, input bit ovl, input bit prt);
        drive(1, a, idl, ill, ovl, prt, 0, 0, 0);
    endtask

    task automatic check_regs(input string tag);
        @(negedge clk);
        req_valid = 0; idle_req = 0; cmd_illegal = 0; prot_overlap = 0; prot_violation = 0;
        reg_wr = 0; reg_sel = 0;
        #1 check({tag, " address register"}, reg_rdata, m_addr);
        reg_sel = 1;
        #1 check({tag, " cause register"}, reg_rdata, {27'b0, m_cause, m_valid});
        check("R9 irq follows valid", {31'b0, irq}, {31'b0, m_valid});
    endtask

    initial begin
        #(200000 * 20);
        check("watchdog expired", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 rsp_valid at reset", {31'b0, rsp_valid}, 0);
        check("R1 irq at reset", {31'b0, irq}, 0);
        reg_sel = 0; #1 check("R1 address register at reset", reg_rdata, 0);
        reg_sel = 1; #1 check("R1 cause register at reset", reg_rdata, 0);
        rst_n = 1;

        // R10: clean requests do not log
        req(32'h0000_0A00, 0, 0, 0, 0);
        req(32'h0000_0A04, 0, 0, 0, 0);
        check_regs("R10 clean");

        // R4, R5: first fault (illegal command) captured, cause bit 2
        req(32'h0000_1000, 0, 1, 0, 0);
        check_regs("R4 R5 first fault");
        check("R5 cause encoding", {27'b0, m_cause, m_valid}, 32'h5);

        // R6: back-to-back faults keep the first record
        req(32'h0000_2000, 0, 0, 1, 0);
        req(32'h0000_3000, 0, 0, 0, 1);
        req(32'h0000_4000, 1, 0, 0, 0);
        req(32'h0000_4004, 0, 0, 0, 0);
        check_regs("R6 locked");

        // R7: writes that must not clear
        drive(0, '0, 0, 0, 0, 0, 1, 1, 0);
        drive(0, '0, 0, 0, 0, 0, 1, 0, 1);
        check_regs("R7 no-op writes");

        // R7: proper clear keeps address
        drive(0, '0, 0, 0, 0, 0, 1, 1, 1);
        check_regs("R7 clear");

        // R5: multiple causes at once (overlap + violation)
        req(32'h0000_5000, 0, 0, 1, 1);
        check_regs("R5 multi-cause");
        check("R5 multi-cause encoding", {27'b0, m_cause, m_valid}, 32'h19);

        // R8: clear and new fault in the same cycle
        drive(1, 32'h0000_6000, 1, 0, 0, 0, 1, 1, 1);
        check_regs("R8 clear with fault");
        check("R8 encoding", {27'b0, m_cause, m_valid}, 32'h3);

        // R7/R10: clear together with a clean request
        drive(1, 32'h0000_7000, 0, 0, 0, 0, 1, 1, 1);
        check_regs("R7 clear with clean request");

        // R2: mixed stream with gaps; every request answered once
        for (int i = 0; i < 12; i++) begin
            if (i % 3 == 2) drive(0, '0, 0, 0, 0, 0, 0, 0, 0);
            else req(32'h0000_8000 + i * 4, i[0], 0, i[2], 0);
        end
        check_regs("R6 R4 stream");
        repeat (2) @(negedge clk);
        check("R2 all responses returned", exp_q.size(), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule